// File: doc/BRIEF.md
# Card Slot Power Sequencer

This block steps a removable card slot through its supply states. The slot supply enable and the card reset line are outputs of the block. Software drives it through a 2-bit power code inside a small status register. Software writes a code to ask for a change, and it reads the same field back to see the current state. A code that asks for an illegal step is dropped, and the state stays as it was.

The states are Off, Prepare, On-Hold, On-Run and Discharge. Reset enters Off, with no supply and reset held. Writing the prepare code moves Off to Prepare, where the supply comes up and reset stays held. Writing the on code then moves Prepare to On-Hold. The block stays in On-Hold, with reset still held, for a fixed settle time, and then moves by itself to On-Run, where reset is released. Writing the shutdown code from Off, Prepare, On-Hold or On-Run enters Discharge. Discharge drops the supply, keeps a fixed discharge time, and then returns to Off by itself. At that point the field reads back as off without any further write.

Top module: `slot_pwr_seq`

## Requirements
- R1: After reset the power field reads 0 (off), `slot_pwr_en` is 0 and `card_rst` is 1.
- R2: The power field is at bits [3:2] of both `wr_data` and `rd_data`. A write decodes only those two bits. All other `rd_data` bits read 0. The field codes are: 0 off, 1 prepare, 2 on, 3 shutdown/discharging.
- R3: Writing code 1 while off enters Prepare. The field reads 1, `slot_pwr_en` is 1 and `card_rst` is 1.
- R4: Writing code 2 while in Prepare enters On. The field reads 2 and `slot_pwr_en` is 1. `card_rst` stays 1 for exactly RST_CYCLES (default 256) cycles after the write edge and is then 0.
- R5: Writing code 3 in any state other than discharging enters Discharge. The field reads 3, `slot_pwr_en` is 0 and `card_rst` is 1. After exactly DISCH_CYCLES (default 1024) cycles from the write edge, the field changes to 0 by itself.
- R6: The following writes are ignored, and the field and both outputs stay unchanged:
  - code 0 in any state;
  - code 2 while off;
  - any code while discharging;
  - code 1 or 2 while on;
  - code 1 while in Prepare.
  A repeated code 2 during the reset hold does not restart the hold.
- R7: `card_rst` is 1 whenever `slot_pwr_en` is 0.
- R8: An accepted write shows in the field and the outputs after the clock edge that samples the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DATA_W | Write data, power code in bits [3:2] |
| rd_data | output | DATA_W | Status read data, current power code in bits [3:2] |
| slot_pwr_en | output | 1 | Slot supply enable |
| card_rst | output | 1 | Card reset, active high |

## Verification
The assertions assume that `wr_en` and `wr_data` are stable across each sampling edge. They also assume that every write lasts a single cycle, so each strobe counts as one request. The bench drives its inputs only on falling edges and pulses `wr_en` for exactly one cycle. It also issues writes inside the reset-hold and discharge windows, so the timed stages are checked while requests are still arriving.

// File: rtl/slot_pwr_pkg.sv
package slot_pwr_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_PREP,
        ST_ON_HOLD,
        ST_ON_RUN,
        ST_DISCHARGE
    } pwr_state_e;

    typedef enum logic [1:0] {
        CODE_OFF      = 2'd0,
        CODE_PREP     = 2'd1,
        CODE_ON       = 2'd2,
        CODE_SHUTDOWN = 2'd3
    } pwr_code_e;

    function automatic pwr_code_e state_to_code(input pwr_state_e st);
        pwr_code_e c;
        unique case (st)
            ST_OFF:       c = CODE_OFF;
            ST_PREP:      c = CODE_PREP;
            ST_ON_HOLD:   c = CODE_ON;
            ST_ON_RUN:    c = CODE_ON;
            ST_DISCHARGE: c = CODE_SHUTDOWN;
            default:      c = CODE_OFF;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/slot_req_decode.sv
module slot_req_decode
    import slot_pwr_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int FIELD_LSB = 2
) (
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              req_vld,
    output pwr_code_e         req_code
);
    logic unused_wr_bits;

    assign unused_wr_bits = ^wr_data;
    assign req_code       = pwr_code_e'(wr_data[FIELD_LSB +: 2]);
    assign req_vld        = wr_en && (req_code != CODE_OFF);
endmodule

// File: rtl/slot_hold_timer.sv
module slot_hold_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/slot_pwr_seq.sv
module slot_pwr_seq
    import slot_pwr_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int FIELD_LSB   = 2,
    parameter int RST_CYCLES  = 256,
    parameter int DISCH_CYCLES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              slot_pwr_en,
    output logic              card_rst
);
    localparam int MAX_CYC = (DISCH_CYCLES > RST_CYCLES) ? DISCH_CYCLES : RST_CYCLES;
    localparam int CNT_W   = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] DISCH_LOAD = CNT_W'(DISCH_CYCLES - 1);
    localparam logic [CNT_W-1:0] HOLD_LOAD  = CNT_W'(RST_CYCLES - 1);

    pwr_state_e       state_q, state_d;
    logic             req_vld;
    pwr_code_e        req_code;
    logic             tmr_load, tmr_run, tmr_expired;
    logic [CNT_W-1:0] tmr_val;
    pwr_code_e        field;

    slot_req_decode #(
        .DATA_W   (DATA_W),
        .FIELD_LSB(FIELD_LSB)
    ) u_dec (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .req_vld (req_vld),
        .req_code(req_code)
    );

    // Transition selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (req_vld && req_code == CODE_PREP)          state_d = ST_PREP;
                else if (req_vld && req_code == CODE_SHUTDOWN) state_d = ST_DISCHARGE;
            end
            ST_PREP: begin
                if (req_vld && req_code == CODE_ON)            state_d = ST_ON_HOLD;
                else if (req_vld && req_code == CODE_SHUTDOWN) state_d = ST_DISCHARGE;
            end
            ST_ON_HOLD: begin
                if (req_vld && req_code == CODE_SHUTDOWN)      state_d = ST_DISCHARGE;
                else if (tmr_expired)                          state_d = ST_ON_RUN;
            end
            ST_ON_RUN: begin
                if (req_vld && req_code == CODE_SHUTDOWN)      state_d = ST_DISCHARGE;
            end
            ST_DISCHARGE: begin
                if (tmr_expired)                               state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Timer control: load on entry to a timed state
    assign tmr_load = (state_d != state_q) &&
                      (state_d == ST_DISCHARGE || state_d == ST_ON_HOLD);
    assign tmr_val  = (state_d == ST_DISCHARGE) ? DISCH_LOAD : HOLD_LOAD;
    assign tmr_run  = (state_q == ST_DISCHARGE) || (state_q == ST_ON_HOLD);

    slot_hold_timer #(
        .CNT_W(CNT_W)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .run     (tmr_run),
        .expired (tmr_expired)
    );

    // Outputs
    always_comb begin
        slot_pwr_en = 1'b0;
        card_rst    = 1'b1;
        unique case (state_q)
            ST_OFF:       begin slot_pwr_en = 1'b0; card_rst = 1'b1; end
            ST_PREP:      begin slot_pwr_en = 1'b1; card_rst = 1'b1; end
            ST_ON_HOLD:   begin slot_pwr_en = 1'b1; card_rst = 1'b1; end
            ST_ON_RUN:    begin slot_pwr_en = 1'b1; card_rst = 1'b0; end
            ST_DISCHARGE: begin slot_pwr_en = 1'b0; card_rst = 1'b1; end
            default:      begin slot_pwr_en = 1'b0; card_rst = 1'b1; end
        endcase
        field   = state_to_code(state_q);
        rd_data = '0;
        rd_data[FIELD_LSB +: 2] = field;
    end
endmodule

// File: rtl/slot_pwr_seq_chk.sv
module slot_pwr_seq_chk #(
    parameter int DATA_W       = 8,
    parameter int FIELD_LSB    = 2,
    parameter int RST_CYCLES   = 256,
    parameter int DISCH_CYCLES = 1024
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              slot_pwr_en,
    input logic              card_rst
);
    logic [1:0] fld, wcode, fld_q;
    int         disch_run, hold_run;
    logic [DATA_W-1:0] spare_mask;

    assign fld   = rd_data[FIELD_LSB +: 2];
    assign wcode = wr_data[FIELD_LSB +: 2];

    always_comb begin
        spare_mask = '1;
        spare_mask[FIELD_LSB +: 2] = 2'b00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fld_q     <= 2'd0;
            disch_run <= 0;
            hold_run  <= 0;
        end else begin
            fld_q     <= fld;
            disch_run <= (fld == 2'd3) ? disch_run + 1 : 0;
            hold_run  <= (fld == 2'd2 && card_rst) ? hold_run + 1 : 0;
        end
    end

    a_r1_off_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        fld == 2'd0 |-> (!slot_pwr_en && card_rst));
    a_r2_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & spare_mask) == '0);
    a_r3_prep_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        fld == 2'd1 |-> (slot_pwr_en && card_rst));
    a_r4_release_in_on: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(card_rst) |-> (fld == 2'd2 && fld_q == 2'd2));
    a_r4_hold_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(card_rst) |-> hold_run == RST_CYCLES);
    a_r5_disch_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        fld == 2'd3 |-> (!slot_pwr_en && card_rst));
    a_r5_disch_length: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_q == 2'd3 && fld == 2'd0) |-> disch_run == DISCH_CYCLES);
    a_r6_off_ignores_on: assert property (@(posedge clk) disable iff (!rst_n)
        (fld == 2'd0 && wr_en && wcode == 2'd2) |=> fld == 2'd0);
    a_r6_disch_exits_off: assert property (@(posedge clk) disable iff (!rst_n)
        fld == 2'd3 |=> (fld == 2'd3 || fld == 2'd0));
    a_r7_rst_without_power: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_pwr_en |-> card_rst);
    a_r8_shutdown_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wcode == 2'd3 && fld != 2'd3) |=> fld == 2'd3);
endmodule

bind slot_pwr_seq slot_pwr_seq_chk #(
    .DATA_W      (DATA_W),
    .FIELD_LSB   (FIELD_LSB),
    .RST_CYCLES  (RST_CYCLES),
    .DISCH_CYCLES(DISCH_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .slot_pwr_en(slot_pwr_en),
    .card_rst   (card_rst)
);

// File: tb/slot_pwr_seq_bench.sv
module slot_pwr_seq_bench;
    localparam int DATA_W = 8;
    localparam int RSTC   = 256;
    localparam int DISC   = 1024;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic              slot_pwr_en, card_rst;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    slot_pwr_seq #(
        .DATA_W(DATA_W), .FIELD_LSB(2), .RST_CYCLES(RSTC), .DISCH_CYCLES(DISC)
    ) u_slot_pwr_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .slot_pwr_en(slot_pwr_en), .card_rst(card_rst)
    );

    // {write code, expected field, expected pwr_en, expected card_rst}
    localparam logic [5:0] VEC [8] = '{
        {2'd2, 2'd0, 1'b0, 1'b1},  // R6 on from off ignored
        {2'd0, 2'd0, 1'b0, 1'b1},  // R6 code 0 ignored
        {2'd1, 2'd1, 1'b1, 1'b1},  // R3 prepare
        {2'd1, 2'd1, 1'b1, 1'b1},  // R6 prepare again ignored
        {2'd0, 2'd1, 1'b1, 1'b1},  // R6 code 0 ignored
        {2'd2, 2'd2, 1'b1, 1'b1},  // R4 on, reset held
        {2'd1, 2'd2, 1'b1, 1'b1},  // R6 prepare while on ignored
        {2'd3, 2'd3, 1'b0, 1'b1}   // R5 shutdown
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_state(input string req, input int f, input bit p, input bit r);
        check(req, int'(rd_data), f << 2);
        check(req, int'(slot_pwr_en), int'(p));
        check(req, int'(card_rst), int'(r));
    endtask

    task automatic write(input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        finish_run();
    end

    initial begin
        wait_cyc(3);
        check_state("R1", 0, 1'b0, 1'b1);
        rst_n = 1'b1;
        wait_cyc(1);
        check_state("R1", 0, 1'b0, 1'b1);

        for (int i = 0; i < 8; i++) begin
            write({4'b0, VEC[i][5:4], 2'b00});
            check_state("R8 vector", int'(VEC[i][3:2]), VEC[i][1], VEC[i][0]);
        end

        // R5: write during discharge ignored; auto return to off after DISC
        write(8'h04);
        check_state("R6 write in discharge", 3, 1'b0, 1'b1);
        wait_cyc(DISC - 3);
        check_state("R5 still discharging", 3, 1'b0, 1'b1);
        wait_cyc(1);
        check_state("R5 back to off", 0, 1'b0, 1'b1);

        // R2: other write bits do not matter
        write(8'hF7);
        check_state("R2 prepare with spare bits", 1, 1'b1, 1'b1);

        // R4: reset hold length, repeated on does not restart it
        write(8'h08);
        check_state("R4 hold start", 2, 1'b1, 1'b1);
        write(8'h08);
        wait_cyc(RSTC - 3);
        check_state("R4 hold last cycle", 2, 1'b1, 1'b1);
        wait_cyc(1);
        check_state("R4 released", 2, 1'b1, 1'b0);
        write(8'h04);
        check_state("R6 prepare in run ignored", 2, 1'b1, 1'b0);
        write(8'h08);
        check_state("R6 on in run ignored", 2, 1'b1, 1'b0);

        // R5/R7: shutdown from run
        write(8'h0C);
        check_state("R5 shutdown from run", 3, 1'b0, 1'b1);
        wait_cyc(DISC);
        check_state("R5 off after run", 0, 1'b0, 1'b1);

        // R5: shutdown from off also discharges
        write(8'h0C);
        check_state("R5 shutdown from off", 3, 1'b0, 1'b1);
        wait_cyc(DISC);
        check_state("R5 off again", 0, 1'b0, 1'b1);

        // R1: reset in the middle of operation
        write(8'h04);
        write(8'h08);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_state("R1 reset while on", 0, 1'b0, 1'b1);
        wait_cyc(2);
        rst_n = 1'b1;
        wait_cyc(2);
        check_state("R1 after reset release", 0, 1'b0, 1'b1);

        finish_run();
    end
endmodule